// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a general-purpose timer. It watches a free-running counter value supplied from outside, compares it against an active compare value, and drives a single registered reference level. A 3-bit mode code selects among eight behaviours: hold, set or clear or invert on a match, force low or high, and two pulse-width modes in which the level follows the sign of the counter-versus-compare comparison.

The compare value is written through a simple write strobe. With the shadow option off, a write lands in the active compare straight away. With it on, the write is parked in a shadow register and copied into the active compare on the next update-event pulse. A fast-response option lets an external trigger pulse act as a compare match in the very cycle it arrives. A protection input, when high, freezes the mode and shadow-enable fields against writes.

Top module: `oc_channel`

## Requirements
- R1: After reset the reference output is 0, the mode is hold (000), the shadow option and fast option are off, and the active and shadow compare values are 0.
- R2: In mode 000 the reference output keeps its value regardless of counter matches, trigger pulses or fast option.
- R3: In mode 001 the reference goes to 1, and in mode 010 to 0, at the clock edge where the counter equals the active compare value (or a fast trigger hit occurs, see R9); otherwise it holds.
- R4: In mode 011 the reference inverts once on the edge of the first cycle in which the counter equals the active compare; further cycles with the counter still equal do not invert it again.
- R5: Mode 100 drives the reference to 0 and mode 101 drives it to 1 at every edge, whatever the counter.
- R6: In mode 110 the reference becomes 1 when counter < active compare and 0 otherwise; in mode 111 it becomes 1 when counter > active compare and 0 otherwise; the level is re-evaluated at every edge.
- R7: With the shadow option off, a compare write changes the active compare at that edge, so the comparison in the following cycle uses the new value.
- R8: With the shadow option on, a compare write leaves the active compare unchanged until an update pulse; the update copies the shadow value, and a write coinciding with an update commits the newly written value.
- R9: With the fast option on, a trigger pulse counts as a match in its own cycle for modes 001, 010 and 011; with the fast option off, trigger pulses have no effect.
- R10: A control write while the protection input is high leaves the mode and the shadow option unchanged but still updates the fast option.
- R11: Changing the mode from 000 to 110 or 111 makes the reference follow the comparison at the first edge after the mode write.
- R12: In mode 011, a trigger hit (fast on) falling in the same cycle as a first match inverts the reference exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | W | Current timer counter value |
| upd_i | input | 1 | Update-event pulse, commits the shadow compare |
| trig_i | input | 1 | Trigger-input event pulse |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | W | Compare value to write |
| ctl_wr_i | input | 1 | Control field write strobe |
| ctl_mode_i | input | 3 | Mode code (000 hold .. 111 second pulse-width mode) |
| ctl_preload_i | input | 1 | Shadow option enable to write |
| ctl_fast_i | input | 1 | Fast trigger option to write |
| prot_lock_i | input | 1 | High blocks writes to mode and shadow option |
| oc_ref_o | output | 1 | Registered reference output level |

## Verification
Two pairs of functions can collide in one cycle: a compare write landing on the same edge as an update pulse, and a fast trigger arriving in the cycle where the counter first reaches the compare value in invert mode. Directed steps place both pairs on the same edge and judge the result against a cycle model in the bench (the new value committed; one inversion, not two), and the random phase fires updates, triggers, writes and mode changes at independent rates over a short counter range so further coincidences occur often.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        OC_HOLD   = 3'b000,
        OC_SET    = 3'b001,
        OC_CLR    = 3'b010,
        OC_INV    = 3'b011,
        OC_LOW    = 3'b100,
        OC_HIGH   = 3'b101,
        OC_PWM_LT = 3'b110,
        OC_PWM_GT = 3'b111
    } oc_mode_e;

    typedef struct packed {
        oc_mode_e mode;
        logic     preload;
        logic     fast;
    } oc_cfg_t;

    // level: a hit exists this cycle; first: the hit starts this cycle
    typedef struct packed {
        logic level;
        logic first;
    } oc_hit_t;

    function automatic logic oc_ref_next(
        input oc_mode_e mode,
        input logic     cur,
        input oc_hit_t  hit,
        input logic     lt,
        input logic     gt
    );
        logic nxt;
        case (mode)
            OC_HOLD:   nxt = cur;
            OC_SET:    nxt = hit.level ? 1'b1 : cur;
            OC_CLR:    nxt = hit.level ? 1'b0 : cur;
            OC_INV:    nxt = hit.first ? ~cur : cur;
            OC_LOW:    nxt = 1'b0;
            OC_HIGH:   nxt = 1'b1;
            OC_PWM_LT: nxt = lt;
            OC_PWM_GT: nxt = gt;
            default:   nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/oc_cfg_regs.sv
module oc_cfg_regs
    import oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [2:0] wr_mode,
    input  logic       wr_preload,
    input  logic       wr_fast,
    input  logic       lock,
    output oc_cfg_t    cfg
);
    oc_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode    <= OC_HOLD;
            cfg_q.preload <= 1'b0;
            cfg_q.fast    <= 1'b0;
        end else if (wr) begin
            cfg_q.fast <= wr_fast;
            if (!lock) begin
                cfg_q.mode    <= oc_mode_e'(wr_mode);
                cfg_q.preload <= wr_preload;
            end
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/oc_cmp_store.sv
module oc_cmp_store #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         upd,
    input  logic         preload,
    output logic [W-1:0] active
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] active_q;
    logic [W-1:0] commit_val;

    assign commit_val = wr ? wdata : shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr) shadow_q <= wdata;
            if (wr && !preload) active_q <= wdata;
            else if (upd)       active_q <= commit_val;
        end
    end

    assign active = active_q;
endmodule

// File: rtl/oc_match_det.sv
module oc_match_det
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic         trig,
    input  logic         fast,
    output oc_hit_t      hit,
    output logic         lt,
    output logic         gt
);
    logic eq;
    logic eq_q;
    logic fast_hit;

    assign eq       = (cnt == cmp);
    assign lt       = (cnt < cmp);
    assign gt       = (cnt > cmp);
    assign fast_hit = trig & fast;

    always_ff @(posedge clk) begin
        if (rst) eq_q <= 1'b0;
        else     eq_q <= eq;
    end

    assign hit.level = eq | fast_hit;
    assign hit.first = (eq & ~eq_q) | fast_hit;
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
    import oc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  oc_mode_e mode,
    input  oc_hit_t  hit,
    input  logic     lt,
    input  logic     gt,
    output logic     ref_o
);
    logic ref_q;

    always_ff @(posedge clk) begin
        if (rst) ref_q <= 1'b0;
        else     ref_q <= oc_ref_next(mode, ref_q, hit, lt, gt);
    end

    assign ref_o = ref_q;
endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt_i,
    input  logic         upd_i,
    input  logic         trig_i,
    input  logic         cmp_wr_i,
    input  logic [W-1:0] cmp_wdata_i,
    input  logic         ctl_wr_i,
    input  logic [2:0]   ctl_mode_i,
    input  logic         ctl_preload_i,
    input  logic         ctl_fast_i,
    input  logic         prot_lock_i,
    output logic         oc_ref_o
);
    oc_cfg_t      cfg;
    oc_hit_t      hit;
    logic [W-1:0] cmp_act;
    logic         cmp_lt;
    logic         cmp_gt;
    logic [2:0]   mode_bits;
    logic         preload_bit;

    assign mode_bits   = cfg.mode;
    assign preload_bit = cfg.preload;

    oc_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr         (ctl_wr_i),
        .wr_mode    (ctl_mode_i),
        .wr_preload (ctl_preload_i),
        .wr_fast    (ctl_fast_i),
        .lock       (prot_lock_i),
        .cfg        (cfg)
    );

    oc_cmp_store #(.W(W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .wr      (cmp_wr_i),
        .wdata   (cmp_wdata_i),
        .upd     (upd_i),
        .preload (cfg.preload),
        .active  (cmp_act)
    );

    oc_match_det #(.W(W)) u_match (
        .clk  (clk),
        .rst  (rst),
        .cnt  (cnt_i),
        .cmp  (cmp_act),
        .trig (trig_i),
        .fast (cfg.fast),
        .hit  (hit),
        .lt   (cmp_lt),
        .gt   (cmp_gt)
    );

    oc_ref_gen u_ref (
        .clk   (clk),
        .rst   (rst),
        .mode  (cfg.mode),
        .hit   (hit),
        .lt    (cmp_lt),
        .gt    (cmp_gt),
        .ref_o (oc_ref_o)
    );
endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmp,
    input logic [2:0]   mode,
    input logic         preload,
    input logic         cmp_wr,
    input logic         upd,
    input logic         ctl_wr,
    input logic         lock,
    input logic         oc_ref
);
    // R1
    a_r1_reset_low: assert property (@(posedge clk) rst |=> !oc_ref);

    // R2
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (mode == OC_HOLD) |=> $stable(oc_ref));

    // R5
    a_r5_force_low: assert property (@(posedge clk) disable iff (rst)
        (mode == OC_LOW) |=> !oc_ref);
    a_r5_force_high: assert property (@(posedge clk) disable iff (rst)
        (mode == OC_HIGH) |=> oc_ref);

    // R6
    a_r6_pwm_lt: assert property (@(posedge clk) disable iff (rst)
        (mode == OC_PWM_LT) |=> (oc_ref == $past(cnt < cmp)));
    a_r6_pwm_gt: assert property (@(posedge clk) disable iff (rst)
        (mode == OC_PWM_GT) |=> (oc_ref == $past(cnt > cmp)));

    // R8
    a_r8_shadow_holds: assert property (@(posedge clk) disable iff (rst)
        (preload && cmp_wr && !upd) |=> $stable(cmp));

    // R10
    a_r10_lock_mode: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && lock) |=> ($stable(mode) && $stable(preload)));
endmodule

bind oc_channel oc_channel_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt_i),
    .cmp     (cmp_act),
    .mode    (mode_bits),
    .preload (preload_bit),
    .cmp_wr  (cmp_wr_i),
    .upd     (upd_i),
    .ctl_wr  (ctl_wr_i),
    .lock    (prot_lock_i),
    .oc_ref  (oc_ref_o)
);

// File: tb/oc_channel_tb.sv
`timescale 1ns/1ps
module oc_channel_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] cnt = '0;
    logic         upd = 1'b0;
    logic         trig = 1'b0;
    logic         cmp_wr = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         ctl_wr = 1'b0;
    logic [2:0]   ctl_mode = 3'b000;
    logic         ctl_pre = 1'b0;
    logic         ctl_fast = 1'b0;
    logic         lock = 1'b0;
    logic         oc_ref;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model state
    logic [2:0]   m_mode;
    logic         m_pre, m_fast, m_eqq, m_ref;
    logic [W-1:0] m_act, m_shadow;

    always #4 clk = ~clk;

    oc_channel #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .cnt_i(cnt), .upd_i(upd), .trig_i(trig),
        .cmp_wr_i(cmp_wr), .cmp_wdata_i(cmp_wdata), .ctl_wr_i(ctl_wr),
        .ctl_mode_i(ctl_mode), .ctl_preload_i(ctl_pre), .ctl_fast_i(ctl_fast),
        .prot_lock_i(lock), .oc_ref_o(oc_ref)
    );

    function automatic logic exp_ref(input logic [2:0] md, input logic cur,
                                     input logic hl, input logic hf,
                                     input logic [W-1:0] c, input logic [W-1:0] a);
        case (md)
            3'b000: return cur;
            3'b001: return hl ? 1'b1 : cur;
            3'b010: return hl ? 1'b0 : cur;
            3'b011: return hf ? ~cur : cur;
            3'b100: return 1'b0;
            3'b101: return 1'b1;
            3'b110: return c < a;
            default: return c > a;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] md);
        case (md)
            3'b000: return "R2";
            3'b001, 3'b010: return "R3";
            3'b011: return "R4";
            3'b100, 3'b101: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic exp);
        n_chk++;
        if (oc_ref !== exp) begin
            n_bad++;
            $display("FAIL %s: oc_ref actual=%b expected=%b at %0t", tag, oc_ref, exp, $time);
        end
    endtask

    // one clock: model updated from pre-edge values, output checked after edge
    task automatic cycle(input string tag);
        logic eq, hl, hf, nref;
        @(posedge clk);
        if (rst) begin
            m_mode = 3'b000; m_pre = 0; m_fast = 0; m_eqq = 0; m_ref = 0;
            m_act = '0; m_shadow = '0;
        end else begin
            eq   = (cnt == m_act);
            hl   = eq | (trig & m_fast);
            hf   = (eq & ~m_eqq) | (trig & m_fast);
            nref = exp_ref(m_mode, m_ref, hl, hf, cnt, m_act);
            m_ref = nref;
            m_eqq = eq;
            if (cmp_wr && !m_pre) m_act = cmp_wdata;
            else if (upd)         m_act = cmp_wr ? cmp_wdata : m_shadow;
            if (cmp_wr) m_shadow = cmp_wdata;
            if (ctl_wr) begin
                m_fast = ctl_fast;
                if (!lock) begin
                    m_mode = ctl_mode;
                    m_pre  = ctl_pre;
                end
            end
        end
        #1;
        check(tag, m_ref);
    endtask

    task automatic set_ctl(input logic [2:0] md, input logic pre, input logic fst, input string tag);
        ctl_wr = 1; ctl_mode = md; ctl_pre = pre; ctl_fast = fst;
        cycle(tag);
        ctl_wr = 0;
    endtask

    task automatic write_cmp(input logic [W-1:0] v, input string tag);
        cmp_wr = 1; cmp_wdata = v;
        cycle(tag);
        cmp_wr = 0;
    endtask

    task automatic sweep(input int lo, input int hi, input string tag);
        for (int i = lo; i <= hi; i++) begin
            cnt = W'(i);
            cycle(tag);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1;
        cycle("R1"); cycle("R1");
        rst = 0;
        // R1: reset state; compare 0, hold mode: match and trigger leave output 0
        cnt = 0; trig = 1; cycle("R1"); trig = 0;
        cnt = 3; cycle("R1");
        // R1 compare 0 visible in second PWM mode (3 > 0)
        set_ctl(3'b111, 0, 0, "R1");
        cycle("R1");

        // R5 force high, then R2 hold keeps it through matches
        set_ctl(3'b101, 0, 1, "R5"); cycle("R5");
        set_ctl(3'b100, 0, 1, "R5"); cycle("R5");
        set_ctl(3'b101, 0, 1, "R5"); cycle("R5");
        set_ctl(3'b000, 0, 1, "R2");
        write_cmp(16'd4, "R2");
        trig = 1; sweep(2, 6, "R2"); trig = 0;

        // R3 set then clear on match
        set_ctl(3'b100, 0, 0, "R5"); cycle("R5");
        set_ctl(3'b001, 0, 0, "R3");
        sweep(0, 3, "R3"); sweep(4, 6, "R3");
        set_ctl(3'b010, 0, 0, "R3");
        sweep(0, 3, "R3"); sweep(4, 6, "R3");

        // R4 invert once while counter stays equal
        set_ctl(3'b011, 0, 0, "R4");
        cnt = 4; cycle("R4"); cycle("R4"); cycle("R4"); cycle("R4");
        cnt = 5; cycle("R4"); cnt = 4; cycle("R4"); cycle("R4");

        // R9 fast off: trigger ignored; fast on: trigger acts as match
        set_ctl(3'b001, 0, 0, "R9");
        set_ctl(3'b100, 0, 0, "R9"); cycle("R9");
        set_ctl(3'b001, 0, 0, "R9");
        cnt = 9; trig = 1; cycle("R9"); trig = 0; cycle("R9");
        set_ctl(3'b001, 0, 1, "R9");
        trig = 1; cycle("R9"); trig = 0; cycle("R9");

        // R12 first match and fast trigger on the same edge: one inversion
        set_ctl(3'b011, 0, 1, "R12");
        cnt = 3; cycle("R12");
        cnt = 4; trig = 1; cycle("R12"); trig = 0; cycle("R12");

        // R6 both comparison modes over a sweep
        set_ctl(3'b110, 0, 0, "R6"); sweep(0, 8, "R6");
        set_ctl(3'b111, 0, 0, "R6"); sweep(0, 8, "R6");

        // R7 immediate compare write
        set_ctl(3'b110, 0, 0, "R7");
        cnt = 6; write_cmp(16'd7, "R7"); cycle("R7");
        write_cmp(16'd5, "R7"); cycle("R7");

        // R8 shadow: held until update, then committed; write+update together
        set_ctl(3'b110, 1, 0, "R8");
        write_cmp(16'd10, "R8"); sweep(5, 9, "R8");
        upd = 1; cycle("R8"); upd = 0; sweep(5, 9, "R8");
        cnt = 8; cmp_wr = 1; cmp_wdata = 16'd2; upd = 1; cycle("R8");
        cmp_wr = 0; upd = 0; cycle("R8"); sweep(0, 3, "R8");

        // R10 lock keeps mode and shadow option, fast still written
        set_ctl(3'b001, 0, 0, "R10");
        set_ctl(3'b100, 0, 0, "R10"); cycle("R10");
        set_ctl(3'b010, 0, 0, "R10");
        lock = 1; set_ctl(3'b101, 1, 1, "R10"); lock = 0;
        cnt = 15; cycle("R10"); cycle("R10");
        trig = 1; cycle("R10"); trig = 0; cycle("R10");
        write_cmp(16'd9, "R10"); cycle("R10");

        // R11 hold to comparison mode switch
        set_ctl(3'b100, 0, 0, "R11"); cycle("R11");
        set_ctl(3'b000, 0, 0, "R11");
        cnt = 1; cycle("R11");
        set_ctl(3'b110, 0, 0, "R11"); cycle("R11");
        set_ctl(3'b000, 0, 0, "R11"); cnt = 12; cycle("R11");
        set_ctl(3'b111, 0, 0, "R11"); cycle("R11");

        // constrained random phase
        for (int k = 0; k < 4000; k++) begin
            cnt    = W'((int'(cnt) + 1) % 16);
            if ($urandom_range(0, 9) == 0) cnt = W'($urandom_range(0, 15));
            upd    = ($urandom_range(0, 7) == 0);
            trig   = ($urandom_range(0, 5) == 0);
            cmp_wr = ($urandom_range(0, 9) == 0);
            cmp_wdata = W'($urandom_range(0, 15));
            ctl_wr = ($urandom_range(0, 24) == 0);
            ctl_mode = 3'($urandom_range(0, 7));
            ctl_pre  = 1'($urandom_range(0, 1));
            ctl_fast = 1'($urandom_range(0, 1));
            lock     = ($urandom_range(0, 4) == 0);
            cycle(tag_of(m_mode));
        end
        upd = 0; trig = 0; cmp_wr = 0; ctl_wr = 0; lock = 0;

        // R1 reset again from a random state
        rst = 1; cycle("R1"); rst = 0;
        cnt = 0; cycle("R1");

        done = 1'b1;
        report();
        $finish;
    end
endmodule